// File: doc/BRIEF.md
# Dual-Clock Parity-Checked Storage Array

This block is the storage core of a FIFO that sits between two clock domains. Words are written through one port on the write clock and fetched through a second port on the read clock. Each port has its own address and strobe, so both can act in the same instant. One parity bit is kept beside every stored word. The bit is formed as the word goes in and checked as it comes out. A word whose parity does not match is never passed on. The port returns zero instead and raises an error flag.

An asynchronous reset starts a sweep over every address on the write clock. The sweep fills the array with zero words that carry correct parity, so a later read of a location that was never written cannot raise a false error. A done flag marks the end of the sweep. User writes are refused until it rises. An output enable gates the read side. While it is low, the data bus is zero and no read takes place.

A build option adds a fault-injection input. When it is set during a write, the inverted parity bit is stored, which gives a way to check the detection path. Another option selects even or odd parity.

Top module: `dual_clock_parity_ram`

## Requirements
- R1: While reset is high and just after it falls, `rd_data` is zero, `rd_valid` is low, `parity_err` is low and `init_done` is low.
- R2: After reset falls, `init_done` rises exactly 2^AW write-clock rising edges later (32 with default parameters) and then stays high until the next reset.
- R3: A write request made while `init_done` is low is ignored. The addressed word still reads back as zero once the sweep completes.
- R4: After the sweep, every address reads back as zero with `parity_err` low.
- R5: A word written with `wr_en` high on a write-clock rising edge (once `init_done` is high) is returned by a later read of the same address.
- R6: A read is taken on a read-clock rising edge when `rd_en` and `out_en` are both high. In the following cycle `rd_valid` is high, together with the data or the error result. After an edge with no read, `rd_valid` is low and `rd_data` is zero.
- R7: While `out_en` is low, `rd_data` is zero and `rd_valid` and `parity_err` are low, even right after a completed read.
- R8: A word written with `tst_par_flip` high holds a wrong parity bit. Reading it gives `rd_data` equal to zero with `parity_err` and `rd_valid` high.
- R9: A read and a write to different addresses, carried out at the same time on their own clocks, do not disturb each other. The read returns the old contents of its own address.
- R10: A clean write to an address that holds a corrupted word restores error-free reads of that address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wr_clk | input | 1 | Write-side clock |
| rd_clk | input | 1 | Read-side clock |
| rst | input | 1 | Asynchronous reset, active high; starts the clearing sweep |
| wr_en | input | 1 | Write strobe |
| wr_addr | input | AW | Write address |
| wr_data | input | DW | Write data |
| tst_par_flip | input | 1 | Stores inverted parity with this write (fault-injection builds only) |
| rd_en | input | 1 | Read strobe |
| rd_addr | input | AW | Read address |
| out_en | input | 1 | Output enable for the read side |
| rd_data | output | DW | Read data, zero on error or when disabled |
| rd_valid | output | 1 | Read result present this cycle |
| parity_err | output | 1 | Parity mismatch on the word just read |
| init_done | output | 1 | Clearing sweep complete, in the write domain |

## Verification
Random writes and reads with random data and addresses are compared against a bench model of the array. In about one write in eight the parity flip is set, which separates a correct error path from one that passes the stored data through. Some of the writes and reads run at the same time on clocks of different periods, and this shows whether the ports are truly independent. Directed cases cover the length of the sweep, writes made during the sweep, a full read-back of the cleared array, gating by the output enable, and repair by rewriting a corrupted word.

// File: rtl/dcpr_pkg.sv
package dcpr_pkg;
   typedef enum logic {PAR_EVEN = 1'b0, PAR_ODD = 1'b1} par_mode_e;

   // parity bit for a word whose XOR reduction is red
   function automatic logic par_bit(input logic red, input par_mode_e mode);
      return red ^ (mode == PAR_ODD);
   endfunction
endpackage

// File: rtl/dcpr_init_seq.sv
module dcpr_init_seq #(
   parameter int AW = 5
) (
   input  logic          clk,
   input  logic          rst,
   output logic [AW-1:0] init_addr,
   output logic          init_done
);
   localparam logic [AW-1:0] LAST = {AW{1'b1}};

   always_ff @(posedge clk or posedge rst) begin
      if (rst) begin
         init_addr <= '0;
         init_done <= 1'b0;
      end else if (!init_done) begin
         if (init_addr == LAST) init_done <= 1'b1;
         else                   init_addr <= init_addr + 1'b1;
      end
   end
endmodule

// File: rtl/dcpr_wr_port.sv
module dcpr_wr_port
   import dcpr_pkg::*;
#(
   parameter int        AW        = 5,
   parameter int        DW        = 32,
   parameter par_mode_e PMODE     = PAR_EVEN,
   parameter bit        FAULT_INJ = 1'b1
) (
   input  logic          init_done,
   input  logic [AW-1:0] init_addr,
   input  logic          wr_en,
   input  logic [AW-1:0] wr_addr,
   input  logic [DW-1:0] wr_data,
   input  logic          flip,
   output logic          mem_we,
   output logic [AW-1:0] mem_addr,
   output logic [DW:0]   mem_word
);
   logic flip_eff;

   generate
      if (FAULT_INJ) begin : g_inj
         assign flip_eff = flip;
      end else begin : g_noinj
         logic unused_flip;
         assign unused_flip = flip;
         assign flip_eff    = 1'b0;
      end
   endgenerate

   always_comb begin
      if (!init_done) begin
         mem_we   = 1'b1;
         mem_addr = init_addr;
         mem_word = {par_bit(1'b0, PMODE), {DW{1'b0}}};
      end else begin
         mem_we   = wr_en;
         mem_addr = wr_addr;
         mem_word = {par_bit(^wr_data, PMODE) ^ flip_eff, wr_data};
      end
   end
endmodule

// File: rtl/dcpr_array.sv
module dcpr_array #(
   parameter int AW = 5,
   parameter int W  = 33
) (
   input  logic          clk,
   input  logic          we,
   input  logic [AW-1:0] waddr,
   input  logic [W-1:0]  wword,
   input  logic [AW-1:0] raddr,
   output logic [W-1:0]  rword
);
   localparam int DEPTH = 1 << AW;

   logic [W-1:0] store [DEPTH];

   always_ff @(posedge clk) begin
      if (we) store[waddr] <= wword;
   end

   assign rword = store[raddr];
endmodule

// File: rtl/dcpr_rd_port.sv
module dcpr_rd_port
   import dcpr_pkg::*;
#(
   parameter int        DW    = 32,
   parameter par_mode_e PMODE = PAR_EVEN
) (
   input  logic          clk,
   input  logic          rst,
   input  logic          rd_en,
   input  logic          out_en,
   input  logic [DW:0]   rword,
   output logic [DW-1:0] rd_data,
   output logic          rd_valid,
   output logic          parity_err
);
   localparam logic EXPECT_RED = (PMODE == PAR_ODD);

   logic          mismatch;
   logic [DW-1:0] data_q;
   logic          valid_q, err_q;

   assign mismatch = (^rword) != EXPECT_RED;

   always_ff @(posedge clk or posedge rst) begin
      if (rst) begin
         data_q  <= '0;
         valid_q <= 1'b0;
         err_q   <= 1'b0;
      end else if (rd_en && out_en) begin
         valid_q <= 1'b1;
         err_q   <= mismatch;
         data_q  <= mismatch ? '0 : rword[DW-1:0];
      end else begin
         valid_q <= 1'b0;
         err_q   <= 1'b0;
         data_q  <= '0;
      end
   end

   assign rd_data    = out_en ? data_q : '0;
   assign rd_valid   = out_en & valid_q;
   assign parity_err = out_en & err_q;
endmodule

// File: rtl/dual_clock_parity_ram.sv
module dual_clock_parity_ram
   import dcpr_pkg::*;
#(
   parameter int        AW        = 5,
   parameter int        DW        = 32,
   parameter par_mode_e PMODE     = PAR_EVEN,
   parameter bit        FAULT_INJ = 1'b1
) (
   input  logic          wr_clk,
   input  logic          rd_clk,
   input  logic          rst,
   input  logic          wr_en,
   input  logic [AW-1:0] wr_addr,
   input  logic [DW-1:0] wr_data,
   input  logic          tst_par_flip,
   input  logic          rd_en,
   input  logic [AW-1:0] rd_addr,
   input  logic          out_en,
   output logic [DW-1:0] rd_data,
   output logic          rd_valid,
   output logic          parity_err,
   output logic          init_done
);
   localparam int WW = DW + 1;

   generate
      if (AW < 1 || AW > 12) begin : g_bad_aw
         $error("dual_clock_parity_ram: AW must be in 1..12");
      end
      if (DW < 1) begin : g_bad_dw
         $error("dual_clock_parity_ram: DW must be positive");
      end
   endgenerate

   logic [AW-1:0] init_addr;
   logic          mem_we;
   logic [AW-1:0] mem_addr;
   logic [WW-1:0] mem_word;
   logic [WW-1:0] rword;

   dcpr_init_seq #(.AW(AW)) u_init (
      .clk       (wr_clk),
      .rst       (rst),
      .init_addr (init_addr),
      .init_done (init_done)
   );

   dcpr_wr_port #(.AW(AW), .DW(DW), .PMODE(PMODE), .FAULT_INJ(FAULT_INJ)) u_wr (
      .init_done (init_done),
      .init_addr (init_addr),
      .wr_en     (wr_en),
      .wr_addr   (wr_addr),
      .wr_data   (wr_data),
      .flip      (tst_par_flip),
      .mem_we    (mem_we),
      .mem_addr  (mem_addr),
      .mem_word  (mem_word)
   );

   dcpr_array #(.AW(AW), .W(WW)) u_mem (
      .clk   (wr_clk),
      .we    (mem_we),
      .waddr (mem_addr),
      .wword (mem_word),
      .raddr (rd_addr),
      .rword (rword)
   );

   dcpr_rd_port #(.DW(DW), .PMODE(PMODE)) u_rd (
      .clk        (rd_clk),
      .rst        (rst),
      .rd_en      (rd_en),
      .out_en     (out_en),
      .rword      (rword),
      .rd_data    (rd_data),
      .rd_valid   (rd_valid),
      .parity_err (parity_err)
   );
endmodule

// File: rtl/dcpr_checker.sv
module dcpr_checker #(
   parameter int AW = 5,
   parameter int DW = 32
) (
   input logic          wr_clk,
   input logic          rd_clk,
   input logic          rst,
   input logic          rd_en,
   input logic [AW-1:0] rd_addr,
   input logic          out_en,
   input logic [DW-1:0] rd_data,
   input logic          rd_valid,
   input logic          parity_err,
   input logic          init_done
);
   logic [AW-1:0] unused_addr;
   assign unused_addr = rd_addr;

   p_done_sticky_r2: assert property (@(posedge wr_clk) disable iff (rst)
      init_done |=> init_done);

   p_read_valid_r6: assert property (@(posedge rd_clk) disable iff (rst)
      (rd_en && out_en) |=> (rd_valid || !out_en));

   p_idle_quiet_r6: assert property (@(posedge rd_clk) disable iff (rst)
      !(rd_en && out_en) |=> !rd_valid);

   p_oe_low_zero_r7: assert property (@(posedge rd_clk) disable iff (rst)
      !out_en |-> (rd_data == '0 && !rd_valid && !parity_err));

   p_err_data_zero_r8: assert property (@(posedge rd_clk) disable iff (rst)
      parity_err |-> rd_data == '0);

   p_err_with_valid_r8: assert property (@(posedge rd_clk) disable iff (rst)
      parity_err |-> rd_valid);
endmodule

bind dual_clock_parity_ram dcpr_checker #(.AW(AW), .DW(DW)) u_chk (
   .wr_clk     (wr_clk),
   .rd_clk     (rd_clk),
   .rst        (rst),
   .rd_en      (rd_en),
   .rd_addr    (rd_addr),
   .out_en     (out_en),
   .rd_data    (rd_data),
   .rd_valid   (rd_valid),
   .parity_err (parity_err),
   .init_done  (init_done)
);

// File: tb/tb_dual_clock_parity_ram.sv
`timescale 1ns/1ps
module tb_dual_clock_parity_ram;
   localparam int AW    = 5;
   localparam int DW    = 32;
   localparam int DEPTH = 1 << AW;

   logic          wr_clk = 1'b0, rd_clk = 1'b0, rst = 1'b1;
   logic          wr_en = 1'b0, tst_par_flip = 1'b0, rd_en = 1'b0, out_en = 1'b0;
   logic [AW-1:0] wr_addr = '0, rd_addr = '0;
   logic [DW-1:0] wr_data = '0;
   logic [DW-1:0] rd_data;
   logic          rd_valid, parity_err, init_done;

   int checks = 0, errors = 0;
   bit finished = 0;

   logic [DW-1:0] model [DEPTH];
   bit            bad   [DEPTH];

   always #5   wr_clk = ~wr_clk;   // 100 MHz
   always #6.5 rd_clk = ~rd_clk;

   dual_clock_parity_ram #(.AW(AW), .DW(DW)) dut (
      .wr_clk(wr_clk), .rd_clk(rd_clk), .rst(rst),
      .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data), .tst_par_flip(tst_par_flip),
      .rd_en(rd_en), .rd_addr(rd_addr), .out_en(out_en),
      .rd_data(rd_data), .rd_valid(rd_valid), .parity_err(parity_err), .init_done(init_done)
   );

   function automatic logic [DW-1:0] exp_data(input logic [AW-1:0] a);
      return bad[a] ? '0 : model[a];
   endfunction

   task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   task automatic do_write(input logic [AW-1:0] a, input logic [DW-1:0] d, input bit flip);
      @(negedge wr_clk);
      wr_en = 1'b1; wr_addr = a; wr_data = d; tst_par_flip = flip;
      @(posedge wr_clk);
      @(negedge wr_clk);
      wr_en = 1'b0; tst_par_flip = 1'b0;
      model[a] = d;
      bad[a]   = flip;
   endtask

   task automatic do_read(input logic [AW-1:0] a, output logic [DW-1:0] d,
                          output logic v, output logic e);
      @(negedge rd_clk);
      rd_en = 1'b1; rd_addr = a; out_en = 1'b1;
      @(posedge rd_clk);
      @(negedge rd_clk);
      rd_en = 1'b0;
      d = rd_data; v = rd_valid; e = parity_err;
   endtask

   task automatic read_check(input string tag, input logic [AW-1:0] a,
                             input logic [DW-1:0] ed, input bit ee);
      logic [DW-1:0] d; logic v, e;
      do_read(a, d, v, e);
      chk({tag, " data"},  d, ed);
      chk({tag, " valid"}, v, 1'b1);
      chk({tag, " err"},   e, ee);
   endtask

   initial begin
      #1ms;
      if (!finished) begin
         checks++; errors++;
         $display("FAIL watchdog actual=timeout expected=finish");
         $display("  CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

   initial begin
      int n;
      logic [DW-1:0] d; logic v, e;
      void'($urandom(32'd2024));
      for (int i = 0; i < DEPTH; i++) begin model[i] = '0; bad[i] = 0; end

      // R1: reset state
      #23;
      chk("R1 data", rd_data, '0);
      chk("R1 valid", rd_valid, 1'b0);
      chk("R1 err", parity_err, 1'b0);
      chk("R1 done", init_done, 1'b0);

      @(negedge wr_clk);
      rst = 1'b0;
      chk("R1 done after release", init_done, 1'b0);
      // R3: write request during the sweep
      wr_en = 1'b1; wr_addr = 5'd5; wr_data = 32'hDEAD_BEEF;
      // R2: count edges until the sweep ends
      n = 0;
      while (!init_done && n < 100) begin
         @(posedge wr_clk); n++; #1;
         if (n == 8) wr_en = 1'b0;
      end
      chk("R2 sweep length", n, DEPTH);
      repeat (3) @(posedge wr_clk);
      #1 chk("R2 done held", init_done, 1'b1);

      // R4 / R3: full read-back of the cleared array
      for (int a = 0; a < DEPTH; a++)
         read_check((a == 5) ? "R3 ignored write" : "R4 cleared", a[AW-1:0], '0, 1'b0);

      // R5 / R6: directed write and read, then an idle edge
      do_write(5'd9, 32'hA5A5_0F0F, 0);
      read_check("R5 readback", 5'd9, 32'hA5A5_0F0F, 1'b0);
      @(posedge rd_clk); @(negedge rd_clk);
      chk("R6 idle valid", rd_valid, 1'b0);
      chk("R6 idle data", rd_data, '0);

      // R7: output enable gating
      do_read(5'd9, d, v, e);
      out_en = 1'b0; #1;
      chk("R7 data gated", rd_data, '0);
      chk("R7 valid gated", rd_valid, 1'b0);
      @(negedge rd_clk); rd_en = 1'b1;
      @(posedge rd_clk); @(negedge rd_clk);
      chk("R7 read blocked data", rd_data, '0);
      chk("R7 read blocked valid", rd_valid, 1'b0);
      rd_en = 1'b0; out_en = 1'b1;

      // R8 / R10: corrupt then repair
      do_write(5'd7, 32'h1234_5678, 1);
      read_check("R8 corrupted", 5'd7, '0, 1'b1);
      do_write(5'd7, 32'h1234_5678, 0);
      read_check("R10 repaired", 5'd7, 32'h1234_5678, 1'b0);

      // R9: directed concurrent access
      begin
         logic [DW-1:0] ed;
         ed = exp_data(5'd9);
         fork
            do_write(5'd3, 32'hCAFE_F00D, 0);
            do_read(5'd9, d, v, e);
         join
         chk("R9 concurrent data", d, ed);
         chk("R9 concurrent valid", v, 1'b1);
         read_check("R9 written word", 5'd3, 32'hCAFE_F00D, 1'b0);
      end

      // random mix
      for (int it = 0; it < 400; it++) begin
         int op;
         logic [AW-1:0] ra, wa;
         logic [DW-1:0] wd, ed;
         bit fl, ee;
         op = $urandom % 3;
         ra = $urandom; wa = $urandom; wd = $urandom;
         fl = ($urandom % 8) == 0;
         if (op == 0) begin
            do_write(wa, wd, fl);
         end else if (op == 1) begin
            read_check(bad[ra] ? "R8 random" : "R5 random", ra, exp_data(ra), bad[ra]);
         end else begin
            if (wa == ra) wa = ra ^ 1'b1;
            ed = exp_data(ra); ee = bad[ra];
            fork
               do_write(wa, wd, fl);
               do_read(ra, d, v, e);
            join
            chk("R9 random data", d, ed);
            chk("R9 random err", e, ee);
            chk("R9 random valid", v, 1'b1);
         end
      end

      finished = 1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule